// File: doc/BRIEF.md
# Two-Wire Register Slave with 16-bit Words

This block is a serial control slave for a two-wire bus. A fast system clock oversamples the already-synchronised bus clock (SCL) and data (SDA) lines. The block detects bus start and stop conditions and answers one fixed 7-bit device address. It drives the data line only through an open-drain enable. When `sda_oe` is high, the pad pulls SDA low.

Registers are 16 bits wide and travel on the wire as two bytes, high byte first. A write carries a register-address byte and then one data word. The address byte also sets a pointer that survives from one transfer to the next. A read has no address phase and returns the word at that pointer. Each committed write appears as a one-cycle strobe on a write port. A separate host-side port reads any register of the file combinationally.

A start condition seen at any bit position abandons the current transfer and re-enters the device-address phase. A stop condition always returns the block to idle.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sda_oe` and `reg_we` are 0, every register reads 0 on the host port, and the register pointer is 0.
- R2: A stop condition (SDA rising while SCL is high) releases SDA on the next cycle and returns the block to idle. In idle, bytes clocked without a preceding start are not acknowledged.
- R3: After a start condition, the first byte is taken MSB first, and its last bit is the direction (1 = read). If the upper 7 bits equal 1110011 (a write byte of 0xE6), the slave holds `sda_oe` high from just after the 8th SCL falling edge until the 9th.
- R4: If the device address does not match, the slave does not acknowledge. It also acknowledges no further byte and writes nothing until the next start.
- R5: In a write, the byte after the device address is the register address, and the next two bytes are the data word, high byte first. After the 9th falling edge of the second data byte, `reg_we` pulses for exactly one cycle, with SCL low. At that moment `reg_waddr` carries the full address byte and `reg_wdata` carries the word. The register selected is given by the low log2(NREGS) bits of the address byte.
- R6: A transfer abandoned before the second data byte has been acknowledged writes nothing.
- R7: In a read, the slave drives the register at the current pointer, high byte first and MSB first. The first data bit comes right after the address acknowledge.
- R8: If the master acknowledges the high byte, the slave sends the low byte. A master NACK after the high byte, or any response after the low byte, releases SDA until the next start or stop.
- R9: A start condition in the middle of any byte restarts the device-address phase, and the following address byte is acknowledged normally.
- R10: The register pointer keeps its value across transfers. A read with no address phase returns the word last written through that pointer.
- R11: Data bytes that follow a complete word in the same write are not acknowledged and are not written.
- R12: `sda_oe` rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | output | 1 | One-cycle commit strobe for a written word |
| reg_waddr | output | 8 | Register address byte of the committed word |
| reg_wdata | output | 16 | Committed word |
| host_raddr | input | AW | Host-side register index |
| host_rdata | output | 16 | Register contents at `host_raddr` |

## Verification
Most internal faults in this block show up within one byte time at the pins. A wrong bit count or a wrong phase makes the acknowledge land on the wrong ninth clock, or makes the block acknowledge a byte that it should ignore. A missed start or stop leaves `sda_oe` stuck, and the next acknowledge check catches that. A corrupt pointer or data path appears later, as a wrong commit seen on the write strobe, or as a wrong byte in a read that uses the pointer without an address phase.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1110011,
  parameter int NREGS = 8,
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [7:0]    reg_waddr,
  output logic [15:0]   reg_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [15:0]   host_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_IGN} st_t;

  st_t         st;
  logic        scl_q, sda_q;
  logic [3:0]  cnt;
  logic [7:0]  sr;
  logic [1:0]  ph;
  logic        rw;
  logic        mnack;
  logic [7:0]  ptr;
  logic [7:0]  hold;
  logic [15:0] txw;
  logic [15:0] regs [NREGS];

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire [15:0] cur = regs[ptr[AW-1:0]];

  assign host_rdata = regs[host_raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      cnt       <= '0;
      sr        <= '0;
      ph        <= '0;
      rw        <= 1'b0;
      mnack     <= 1'b1;
      ptr       <= '0;
      hold      <= '0;
      txw       <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      reg_we <= 1'b0;
      if (start_c) begin
        st     <= S_RX;
        ph     <= 2'd0;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (ph == 2'd0) begin
                if (sr[7:1] == DEV_ADDR) begin
                  rw     <= sr[0];
                  sda_oe <= 1'b1;
                  st     <= S_ACK;
                end else begin
                  st <= S_IGN;
                end
              end else begin
                if (ph == 2'd1) ptr  <= sr;
                if (ph == 2'd2) hold <= sr;
                sda_oe <= 1'b1;
                st     <= S_ACK;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (ph == 2'd0 && rw) begin
                sda_oe <= ~cur[15];
                txw    <= {cur[14:0], 1'b0};
                cnt    <= '0;
                st     <= S_TX;
              end else if (ph == 2'd3) begin
                regs[ptr[AW-1:0]] <= {hold, sr};
                reg_we    <= 1'b1;
                reg_waddr <= ptr;
                reg_wdata <= {hold, sr};
                st        <= S_IGN;
              end else begin
                ph <= ph + 2'd1;
                st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= S_MACK;
              end else begin
                sda_oe <= ~txw[15];
                txw    <= {txw[14:0], 1'b0};
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mnack <= sda_i;
            end else if (scl_fall) begin
              if (!mnack && ph == 2'd0) begin
                ph     <= 2'd1;
                sda_oe <= ~txw[15];
                txw    <= {txw[14:0], 1'b0};
                st     <= S_TX;
              end else begin
                st <= S_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] waddr_lo,
  input logic [15:0]   reg_wdata,
  input logic [AW-1:0] host_raddr,
  input logic [15:0]   host_rdata
);

  assert_oe_rise_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_we_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_i);

  assert_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && waddr_lo == host_raddr) |=>
      (host_raddr != $past(host_raddr) || host_rdata == $past(reg_wdata)));

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe);

  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> !sda_oe);

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .waddr_lo(reg_waddr[AW-1:0]), .reg_wdata(reg_wdata),
  .host_raddr(host_raddr), .host_rdata(host_rdata)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int AW = 3;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [AW-1:0] host_raddr = '0;
  logic sda_oe, reg_we;
  logic [7:0] reg_waddr;
  logic [15:0] reg_wdata, host_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];

  always #5 clk = ~clk;

  i2c_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every commit must match the next expected word
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected commit", {8'h0, reg_waddr, reg_wdata}, 32'h0);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({reg_waddr, reg_wdata} == e, "R5 commit", {8'h0, reg_waddr, reg_wdata}, {8'h0, e});
      end
    end
  end

  // R12: open-drain enable must never rise while SCL is high
  logic oe_q = 1'b0;
  int oe_bad = 0;
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_q && scl_m) oe_bad++;
    oe_q <= sda_oe;
  end

  task automatic bus_start;
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H / 2);
    ack = sda_bus;
    tick(H / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1'b1; tick(H / 2);
      b[i] = sda_bus;
      tick(H / 2);
      scl_m = 1'b0; tick(2);
    end
    send_bit(nack);
  endtask

  task automatic write_word(input logic [7:0] ra, input logic [15:0] d, input string req);
    logic a;
    bus_start;
    send_byte(8'hE6, a); chk(a == 1'b0, "R3 address ack", 32'(a), 32'h0);
    send_byte(ra, a);    chk(a == 1'b0, req, 32'(a), 32'h0);
    exp_q.push_back({ra, d});
    send_byte(d[15:8], a); chk(a == 1'b0, req, 32'(a), 32'h0);
    send_byte(d[7:0], a);  chk(a == 1'b0, req, 32'(a), 32'h0);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    tick(4);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe", 32'(sda_oe), 32'h0);
    chk(reg_we == 1'b0, "R1 reg_we", 32'(reg_we), 32'h0);
    rst_n = 1'b1;
    tick(2);
    for (int i = 0; i < 8; i++) begin
      host_raddr = AW'(i); tick(1);
      chk(host_rdata == 16'h0, "R1 reg clear", 32'(host_rdata), 32'h0);
    end

    // R5 basic write
    write_word(8'h03, 16'hBEEF, "R5 write ack");
    bus_stop;
    host_raddr = 3'd3; tick(1);
    chk(host_rdata == 16'hBEEF, "R5 host read", 32'(host_rdata), 32'hBEEF);

    // R7/R8/R10 read at pointer 3, no register address phase
    bus_start;
    send_byte(8'hE7, a); chk(a == 1'b0, "R3 read address ack", 32'(a), 32'h0);
    recv_byte(1'b0, b);  chk(b == 8'hBE, "R7 high byte", 32'(b), 32'hBE);
    recv_byte(1'b1, b);  chk(b == 8'hEF, "R8 low byte", 32'(b), 32'hEF);
    bus_stop;
    chk(sda_oe == 1'b0, "R2 released after stop", 32'(sda_oe), 32'h0);

    // R4 wrong device address
    bus_start;
    send_byte(8'hA0, a); chk(a == 1'b1, "R4 no ack", 32'(a), 32'h1);
    send_byte(8'h01, a); chk(a == 1'b1, "R4 ignored byte", 32'(a), 32'h1);
    send_byte(8'h12, a); chk(a == 1'b1, "R4 ignored byte", 32'(a), 32'h1);
    bus_stop;
    host_raddr = 3'd1; tick(1);
    chk(host_rdata == 16'h0, "R4 no write", 32'(host_rdata), 32'h0);

    // R6/R9 abort mid low byte by a start, then a fresh write
    bus_start;
    send_byte(8'hE6, a); send_byte(8'h05, a); send_byte(8'h11, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    write_word(8'h06, 16'h2233, "R9 restart ack");
    bus_stop;
    host_raddr = 3'd5; tick(1);
    chk(host_rdata == 16'h0, "R6 aborted word", 32'(host_rdata), 32'h0);

    // R9 start in the middle of an address byte; R10 pointer kept at 6; R8 NACK
    bus_start;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start;
    send_byte(8'hE7, a); chk(a == 1'b0, "R9 mid-byte restart ack", 32'(a), 32'h0);
    recv_byte(1'b1, b);  chk(b == 8'h22, "R10 pointer read", 32'(b), 32'h22);
    recv_byte(1'b1, b);  chk(b == 8'hFF, "R8 released after NACK", 32'(b), 32'hFF);
    bus_stop;

    // R11 extra byte after a word
    write_word(8'h02, 16'h1234, "R5 write ack");
    send_byte(8'h56, a); chk(a == 1'b1, "R11 extra byte", 32'(a), 32'h1);
    bus_stop;
    host_raddr = 3'd2; tick(1);
    chk(host_rdata == 16'h1234, "R11 word kept", 32'(host_rdata), 32'h1234);

    // R5 low address bits select the register (0x0A -> index 2)
    write_word(8'h0A, 16'hABCD, "R5 alias ack");
    bus_stop;
    tick(1);
    chk(host_rdata == 16'hABCD, "R5 alias index", 32'(host_rdata), 32'hABCD);

    // R8 after low byte the slave releases even if acknowledged
    bus_start;
    send_byte(8'hE7, a);
    recv_byte(1'b0, b); chk(b == 8'hAB, "R7 high byte", 32'(b), 32'hAB);
    recv_byte(1'b0, b); chk(b == 8'hCD, "R8 low byte", 32'(b), 32'hCD);
    recv_byte(1'b0, b); chk(b == 8'hFF, "R8 released after low byte", 32'(b), 32'hFF);
    bus_stop;

    // R2 idle ignores bytes without start
    send_byte(8'hE6, a); chk(a == 1'b1, "R2 idle no ack", 32'(a), 32'h1);
    bus_start;
    bus_stop;

    tick(10);
    chk(exp_q.size() == 0, "R5 pending commits", 32'(exp_q.size()), 32'h0);
    chk(oe_bad == 0, "R12 oe rose with SCL high", 32'(oe_bad), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule